// File: doc/BRIEF.md
# Packet Buffer Byte Window with Auto-Advancing Pointer

This block lets a host reach individual bytes of a paged packet buffer RAM through a small register window. A 16-bit pointer is loaded one byte at a time. Its top bit picks the page: either the page at the head of the receive queue, or the page the host has chosen in its packet number register. Its low 11 bits give the byte index inside a 2048-byte page. A four-byte data window at host offsets 8 to 11 then reads or writes that RAM location.

The next bit down picks between two addressing styles. In stepping mode every window access uses the pointer index and then moves the index on by one, so a host can stream through a page at any window offset. In lane mode the pointer stays fixed and the window offset's two low bits are added to the index, so four neighbouring bytes can be reached without reloading the pointer. All index arithmetic wraps inside the page.

A combinational decoder sorts each host access into one of four access classes: `ACC_NONE`, `ACC_PTR_LO`, `ACC_PTR_HI` and `ACC_DATA`. The class selects both the read mux and the pointer update. The pointer register is the only state. Its transitions are: reset to zero, low-half load, high-half load, index step, and hold.

Top module: `buf_data_port`

## Requirements
- R1: After reset the pointer is zero, so the low pointer byte (offset 6) and the high pointer byte (offset 7) both read 0x00.
- R2: A write to offset 6 replaces only pointer bits 7:0. A write to offset 7 replaces only pointer bits 15:8.
- R3: A read of offset 7 returns pointer bits 15:8 ANDed with 0xF7, so bit 3 of that byte always reads 0. A read of offset 6 returns bits 7:0 unmasked.
- R4: When pointer bit 15 is 1, `ram_page` equals `rx_head`. When bit 15 is 0, `ram_page` equals `pkt_num`.
- R5: When pointer bit 14 is 0, a window access at offset 8+k (k = 0..3) addresses byte index (pointer[10:0] + k) mod 2048, and the pointer is left unchanged.
- R6: When pointer bit 14 is 1, a window access (read or write, at any of offsets 8..11) addresses pointer[10:0]. At the end of that cycle pointer[10:0] becomes (pointer[10:0] + 1) mod 2048 and pointer[15:11] is kept.
- R7: `ram_we` is high only in a cycle with a host write to offsets 8..11. In that cycle `ram_wdata` carries the host write byte. Pointer writes never pulse `ram_we`.
- R8: A host read of offsets 8..11 returns `ram_rdata` in the same cycle as the read strobe.
- R9: Reads of offsets other than 6..11 return 0x00. Writes to them change neither the pointer nor the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_off | input | 4 | Byte offset of the host access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational |
| pkt_num | input | 2 | Page chosen by the host packet number register |
| rx_head | input | 2 | Page at the head of the receive queue |
| ram_page | output | 2 | Page presented to the buffer RAM |
| ram_addr | output | 11 | Byte index inside the page |
| ram_we | output | 1 | RAM byte write enable |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte for the presented address |

## Verification
Assertions check four things on every cycle:
- a stepping access advances only the index, wrapping it, and keeps the upper pointer bits;
- a lane-mode or non-window access leaves the pointer alone;
- each half-load keeps the other half;
- the RAM write enable and the masked high-byte read stay within their rules.

Only the bench scenarios can show the rest: the exact index produced by each lane offset across the page wrap, the page choice between the two page sources, the byte that lands in the RAM, and the read data returned for each window offset.

// File: rtl/buf_data_port_pkg.sv
package buf_data_port_pkg;
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_PTR_LO = 2'd1,
        ACC_PTR_HI = 2'd2,
        ACC_DATA   = 2'd3
    } acc_e;

    localparam int OFF_PTR_LO = 6;
    localparam int OFF_PTR_HI = 7;
    localparam int OFF_WIN_LO = 8;
    localparam int OFF_WIN_HI = 11;
    localparam int PTR_W      = 16;
    localparam int BYTE_W     = 8;
    localparam logic [BYTE_W-1:0] HI_READ_MASK = 8'hF7;
endpackage

// File: rtl/dpp_decode.sv
module dpp_decode
    import buf_data_port_pkg::*;
#(
    parameter int OFF_W = 4
) (
    input  logic [OFF_W-1:0] off,
    output acc_e             cls
);
    always_comb begin
        unique case (off)
            OFF_W'(OFF_PTR_LO): cls = ACC_PTR_LO;
            OFF_W'(OFF_PTR_HI): cls = ACC_PTR_HI;
            OFF_W'(OFF_WIN_LO),
            OFF_W'(OFF_WIN_LO + 1),
            OFF_W'(OFF_WIN_LO + 2),
            OFF_W'(OFF_WIN_HI): cls = ACC_DATA;
            default:            cls = ACC_NONE;
        endcase
    end
endmodule

// File: rtl/dpp_ptr_reg.sv
module dpp_ptr_reg
    import buf_data_port_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              step,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [PTR_W-1:0]  ptr
);
    localparam int HI_LSB = PTR_W - BYTE_W;

    logic [PTR_W-1:0] ptr_nxt;

    always_comb begin
        ptr_nxt = ptr;
        if (ld_lo) begin
            ptr_nxt[BYTE_W-1:0] = wbyte;
        end else if (ld_hi) begin
            ptr_nxt[PTR_W-1:HI_LSB] = wbyte;
        end else if (step) begin
            ptr_nxt[IDX_W-1:0] = ptr[IDX_W-1:0] + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            ptr <= ptr_nxt;
        end
    end

    // R6: a step wraps the index and keeps the upper bits
    assert_autoinc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_lo && !ld_hi) |=>
            (ptr[IDX_W-1:0] == $past(ptr[IDX_W-1:0]) + IDX_W'(1)) &&
            (ptr[PTR_W-1:IDX_W] == $past(ptr[PTR_W-1:IDX_W])));

    // R5 / R9: with no load and no step, the pointer holds
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld_lo && !ld_hi) |=> $stable(ptr));

    // R2: a low-half load keeps the high half
    assert_lo_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (ptr[PTR_W-1:HI_LSB] == $past(ptr[PTR_W-1:HI_LSB])));

    // R2: a high-half load keeps the low half
    assert_hi_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !ld_lo) |=> (ptr[BYTE_W-1:0] == $past(ptr[BYTE_W-1:0])));
endmodule

// File: rtl/dpp_addr_gen.sv
module dpp_addr_gen
    import buf_data_port_pkg::*;
#(
    parameter int IDX_W  = 11,
    parameter int PAGE_W = 2
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [1:0]        lane,
    input  logic [PAGE_W-1:0] pkt_num,
    input  logic [PAGE_W-1:0] rx_head,
    output logic [PAGE_W-1:0] page,
    output logic [IDX_W-1:0]  addr,
    output logic              stepping
);
    localparam int SEL_BIT  = PTR_W - 1;
    localparam int AUTO_BIT = PTR_W - 2;

    assign stepping = ptr[AUTO_BIT];
    assign page     = ptr[SEL_BIT] ? rx_head : pkt_num;
    assign addr     = stepping ? ptr[IDX_W-1:0]
                               : ptr[IDX_W-1:0] + IDX_W'(lane);
endmodule

// File: rtl/buf_data_port.sv
module buf_data_port
    import buf_data_port_pkg::*;
#(
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 11,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [PAGE_W-1:0] pkt_num,
    input  logic [PAGE_W-1:0] rx_head,
    output logic [PAGE_W-1:0] ram_page,
    output logic [IDX_W-1:0]  ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);
    localparam int HI_LSB = PTR_W - BYTE_W;

    acc_e             cls;
    logic [PTR_W-1:0] ptr;
    logic             stepping;
    logic             win_hit;

    dpp_decode #(.OFF_W(OFF_W)) u_dec (
        .off (host_off),
        .cls (cls)
    );

    dpp_addr_gen #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_agen (
        .ptr      (ptr),
        .lane     (host_off[1:0]),
        .pkt_num  (pkt_num),
        .rx_head  (rx_head),
        .page     (ram_page),
        .addr     (ram_addr),
        .stepping (stepping)
    );

    assign win_hit = (cls == ACC_DATA) && (host_rd || host_wr);

    dpp_ptr_reg #(.IDX_W(IDX_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (host_wr && (cls == ACC_PTR_LO)),
        .ld_hi (host_wr && (cls == ACC_PTR_HI)),
        .step  (win_hit && stepping),
        .wbyte (host_wdata),
        .ptr   (ptr)
    );

    assign ram_we    = host_wr && (cls == ACC_DATA);
    assign ram_wdata = host_wdata;

    always_comb begin
        unique case (cls)
            ACC_PTR_LO: host_rdata = ptr[BYTE_W-1:0];
            ACC_PTR_HI: host_rdata = ptr[PTR_W-1:HI_LSB] & HI_READ_MASK;
            ACC_DATA:   host_rdata = ram_rdata;
            default:    host_rdata = '0;
        endcase
    end

    // R7: the RAM is written only by a host write in the data window
    assert_we_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (host_wr && host_off >= OFF_W'(OFF_WIN_LO)
                            && host_off <= OFF_W'(OFF_WIN_HI)));

    // R3: bit 3 of the high pointer byte never reads back as 1
    assert_hi_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_off == OFF_W'(OFF_PTR_HI)) |-> (host_rdata[3] == 1'b0));

    // R9: reads outside offsets 6..11 return zero
    assert_zero_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (host_off < OFF_W'(OFF_PTR_LO) || host_off > OFF_W'(OFF_WIN_HI)))
            |-> (host_rdata == 8'h00));
endmodule

// File: tb/buf_data_port_tb.sv
module buf_data_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [3:0]  host_off = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [1:0]  pkt_num = 2'd1;
    logic [1:0]  rx_head = 2'd2;
    logic [1:0]  ram_page;
    logic [10:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;

    int total = 0;
    int bad = 0;

    logic        wr_seen;
    logic [1:0]  wr_page;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;

    always #5 clk = ~clk;

    function automatic logic [7:0] ram_f(input logic [1:0] pg, input logic [10:0] a);
        return a[7:0] ^ {a[10:8], 5'b0} ^ {pg, 6'b0};
    endfunction

    assign ram_rdata = ram_f(ram_page, ram_addr);

    always_ff @(posedge clk) begin
        if (ram_we) begin
            wr_seen <= 1'b1;
            wr_page <= ram_page;
            wr_addr <= ram_addr;
            wr_data <= ram_wdata;
        end
    end

    buf_data_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pkt_num(pkt_num), .rx_head(rx_head), .ram_page(ram_page),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        host_off = off; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_byte(input logic [3:0] off, output logic [7:0] d,
                           output logic [1:0] pg, output logic [10:0] a);
        @(negedge clk);
        host_off = off; host_rd = 1'b1;
        #1;
        d = host_rdata; pg = ram_page; a = ram_addr;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic get_ptr(output logic [15:0] p);
        logic [7:0] lo, hi;
        logic [1:0] pg;
        logic [10:0] a;
        rd_byte(4'd6, lo, pg, a);
        rd_byte(4'd7, hi, pg, a);
        p = {hi, lo};
    endtask

    task automatic set_ptr(input logic [15:0] p);
        wr_byte(4'd6, p[7:0]);
        wr_byte(4'd7, p[15:8]);
    endtask

    task automatic t_reset;
        logic [15:0] p;
        get_ptr(p);
        chk("R1", "pointer after reset", p, 16'h0000);
    endtask

    task automatic t_halves;
        logic [15:0] p;
        set_ptr(16'h125A);
        get_ptr(p);
        chk("R2", "both halves loaded", p, 16'h125A);
        wr_byte(4'd6, 8'h33);
        get_ptr(p);
        chk("R2", "low write keeps high", p, 16'h1233);
        wr_byte(4'd7, 8'hFF);
        get_ptr(p);
        chk("R3", "high read masked, low kept", p, 16'hF733);
    endtask

    task automatic t_lanes;
        logic [7:0] d;
        logic [1:0] pg;
        logic [10:0] a;
        logic [15:0] p;
        pkt_num = 2'd1;
        set_ptr(16'h07FE);
        for (int k = 0; k < 4; k++) begin
            rd_byte(4'(8 + k), d, pg, a);
            chk("R5", "lane index", a, (11'h7FE + k) & 11'h7FF);
            chk("R4", "lane page from packet number", pg, 1);
            chk("R8", "lane read data", d, ram_f(2'd1, 11'((11'h7FE + k) & 11'h7FF)));
        end
        get_ptr(p);
        chk("R5", "pointer unchanged by lane reads", p, 16'h07FE);
    endtask

    task automatic t_page_sel;
        logic [7:0] d;
        logic [1:0] pg;
        logic [10:0] a;
        set_ptr(16'h8010);
        rx_head = 2'd2;
        rd_byte(4'd9, d, pg, a);
        chk("R4", "page from rx head", pg, 2);
        chk("R5", "index with lane 1", a, 11'h011);
        chk("R8", "rx head page data", d, ram_f(2'd2, 11'h011));
        rx_head = 2'd3;
        rd_byte(4'd8, d, pg, a);
        chk("R4", "page follows rx head", pg, 3);
    endtask

    task automatic t_auto;
        logic [7:0] d;
        logic [1:0] pg;
        logic [10:0] a;
        logic [15:0] p;
        pkt_num = 2'd1;
        set_ptr(16'h47FE);
        rd_byte(4'd10, d, pg, a);
        chk("R6", "stepping ignores lane", a, 11'h7FE);
        rd_byte(4'd8, d, pg, a);
        chk("R6", "stepped once", a, 11'h7FF);
        chk("R8", "stepping read data", d, ram_f(2'd1, 11'h7FF));
        wr_seen = 1'b0;
        wr_byte(4'd11, 8'hC3);
        chk("R6", "write at wrapped index", wr_addr, 11'h000);
        chk("R7", "stepping write data", wr_data, 8'hC3);
        get_ptr(p);
        chk("R6", "index wrapped, upper kept", p, 16'h4001);
    endtask

    task automatic t_write_path;
        logic [15:0] p;
        pkt_num = 2'd3;
        set_ptr(16'h0100);
        wr_seen = 1'b0;
        wr_byte(4'd9, 8'hA5);
        chk("R7", "write seen", wr_seen, 1);
        chk("R7", "write page", wr_page, 3);
        chk("R7", "write index", wr_addr, 11'h101);
        chk("R7", "write byte", wr_data, 8'hA5);
        wr_seen = 1'b0;
        wr_byte(4'd6, 8'h00);
        chk("R7", "pointer write does not hit RAM", wr_seen, 0);
        get_ptr(p);
        chk("R5", "lane write leaves pointer", p, 16'h0100);
    endtask

    task automatic t_other;
        logic [7:0] d;
        logic [1:0] pg;
        logic [10:0] a;
        logic [15:0] p;
        set_ptr(16'h4123);
        wr_seen = 1'b0;
        wr_byte(4'd3, 8'hFF);
        wr_byte(4'd12, 8'hFF);
        get_ptr(p);
        chk("R9", "pointer after stray writes", p, 16'h4123);
        chk("R9", "no RAM write from stray offsets", wr_seen, 0);
        rd_byte(4'd12, d, pg, a);
        chk("R9", "offset 12 reads zero", d, 0);
        rd_byte(4'd5, d, pg, a);
        chk("R9", "offset 5 reads zero", d, 0);
        get_ptr(p);
        chk("R9", "stray reads do not step", p, 16'h4123);
    endtask

    initial begin
        wr_seen = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_halves();
        t_lanes();
        t_page_sel();
        t_auto();
        t_write_path();
        t_other();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule